// File: doc/BRIEF.md
# Low-Power-Mode Handshake Controller

This block sits on the host side of a four-wire sleep handshake between a host and a wireless controller module. Two of the wires carry sleep permission, one in each direction. Permission is granted by driving the line low. The other two wires are the UART flow-control pair. No serial commands take part. Either side gets out of low-power mode purely by signal levels.

Host firmware sends single-cycle sleep and wake request pulses. The controller lets the module sleep by first raising the module's clear-to-send and then lowering the permission line. It reports that the host may sleep only once the module has raised its ready-to-send and lowered its own permission line. The wake sequence reverses the order: clear-to-send goes low first, then permission goes high. When the module wakes the host, the controller emits a wake event. It also blocks transmission while the module's ready-to-send is high.

The two lines from the module pass through a two-stage synchronizer. A configurable watchdog raises an error when the module does not answer a host wake within a set number of cycles.

Top module: `lpm_handshake_ctrl`

## Requirements
- R1: Reset values: `peer_sleep_ok_n` = 1, `peer_cts_n` = 0, `host_sleep_ok` = 0, `host_wake_evt` = 0, `tx_hold` = 0, `wake_timeout` = 0. This holds both at power-up and when reset is applied in the middle of a sequence.
- R2: A `sleep_req` pulse while awake makes `peer_cts_n` rise at the next clock edge. `peer_sleep_ok_n` then falls one edge later, never before `peer_cts_n` is high.
- R3: `host_sleep_ok` rises only after sleep was granted to the module and the module shows RTS = 1 and permission = 0. The rise comes on the third edge after those module lines change.
- R4: A `wake_req` pulse while sleep is granted or both sides sleep makes `peer_cts_n` fall at the next edge and `peer_sleep_ok_n` rise one edge later. `host_sleep_ok` drops at the same edge as `peer_cts_n`.
- R5: A host wake completes, and new sleep requests are accepted again, on the third edge after the module's RTS goes low.
- R6: While both sides sleep, a module wake (RTS = 0 and permission = 1) produces a one-cycle `host_wake_evt` on the third edge after the change. On that same edge `peer_cts_n` falls and `host_sleep_ok` drops; `peer_sleep_ok_n` rises one edge later.
- R7: `tx_hold` follows `mod_rts_n`, delayed by three edges.
- R8: `wake_timeout` rises on the TIMEOUT_CYCLES-th edge, counting the edge that started the host wake, if the module's RTS is still high. It stays high until the wake completes and clears on that edge.
- R9: A `sleep_req` while not awake is ignored, and a `wake_req` while awake is ignored.
- R10: While awake, module line changes (RTS high, permission low) do not put the host to sleep or change `peer_cts_n` or `peer_sleep_ok_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Firmware pulse: let the module sleep |
| wake_req | input | 1 | Firmware pulse: wake the module |
| mod_sleep_ok_n | input | 1 | Module's permission line to the host, low = host may sleep |
| mod_rts_n | input | 1 | Module's RTS, high = host must not send |
| peer_sleep_ok_n | output | 1 | Permission to the module, low = module may sleep |
| peer_cts_n | output | 1 | Drives the module's CTS, high = module must not send |
| host_sleep_ok | output | 1 | Both sides have agreed the host may sleep |
| host_wake_evt | output | 1 | One-cycle pulse when the module wakes the host |
| tx_hold | output | 1 | Host transmission blocked |
| wake_timeout | output | 1 | Module did not answer a host wake in time |

## Verification
The hardest state to reach is a host wake that the module never answers. To get there, the controller must first reach the both-asleep state. The module lines must then be held asleep across the whole watchdog window after `wake_req`. The bench sets up this case directly. It samples `wake_timeout` one edge before and at the limit edge. It then releases the module's RTS and checks that the flag stays set until the third edge and clears on that edge. A module-initiated wake also needs the full sleep handshake first. The bench therefore reaches it through a table of per-edge vectors that accounts for the three-edge latency of the synchronizer.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE   = 2'd0,
    ST_GRANTED = 2'd1,
    ST_ASLEEP  = 2'd2,
    ST_WAKING  = 2'd3
  } lpm_state_t;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic in_waking,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (!in_waking) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      if (cnt != TOP) cnt <= cnt + 1'b1;
      if (cnt == LAST) expired <= 1'b1;
    end
  end

  // expiry needs a full window of waking cycles behind it
  assert_no_early_expiry_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(expired) |-> $past(in_waking));
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sleep_req,
  input  logic wake_req,
  input  logic mod_ok_n_s,
  input  logic mod_rts_n_s,
  input  logic timeout_flag,
  output logic waking_next,
  output logic peer_sleep_ok_n,
  output logic peer_cts_n,
  output logic host_sleep_ok,
  output logic host_wake_evt,
  output logic tx_hold
);
  lpm_state_t state, nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_AWAKE:   if (sleep_req) nxt = ST_GRANTED;
      ST_GRANTED: if (wake_req) nxt = ST_WAKING;
                  else if (mod_rts_n_s && !mod_ok_n_s) nxt = ST_ASLEEP;
      ST_ASLEEP:  if (wake_req) nxt = ST_WAKING;
                  else if (!mod_rts_n_s && mod_ok_n_s) nxt = ST_AWAKE;
      ST_WAKING:  if (!mod_rts_n_s) nxt = ST_AWAKE;
      default:    nxt = ST_AWAKE;
    endcase
  end

  assign waking_next = (nxt == ST_WAKING);

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_AWAKE;
      peer_cts_n      <= 1'b0;
      peer_sleep_ok_n <= 1'b1;
      host_sleep_ok   <= 1'b0;
      host_wake_evt   <= 1'b0;
      tx_hold         <= 1'b0;
    end else begin
      state           <= nxt;
      // CTS follows the next state; permission lags one edge behind it
      peer_cts_n      <= (nxt == ST_GRANTED) || (nxt == ST_ASLEEP);
      peer_sleep_ok_n <= !((state == ST_GRANTED) || (state == ST_ASLEEP));
      host_sleep_ok   <= (nxt == ST_ASLEEP);
      host_wake_evt   <= (state == ST_ASLEEP) && (nxt == ST_AWAKE);
      tx_hold         <= mod_rts_n_s;
    end
  end

  assert_cts_before_grant_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(peer_sleep_ok_n) |-> (peer_cts_n && $past(peer_cts_n)));

  assert_cts_low_before_wake_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(peer_sleep_ok_n) |-> (!peer_cts_n && !$past(peer_cts_n)));

  assert_sleep_needs_module_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(host_sleep_ok) |-> $past(mod_rts_n_s && !mod_ok_n_s));

  assert_event_single_R6: assert property (@(posedge clk) disable iff (rst)
    host_wake_evt |=> !host_wake_evt);

  assert_timeout_only_waking_R8: assert property (@(posedge clk) disable iff (rst)
    timeout_flag |-> (state == ST_WAKING));
endmodule

// File: rtl/lpm_handshake_ctrl.sv
module lpm_handshake_ctrl #(
  parameter int TIMEOUT_CYCLES = 1024,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_req,
  input  logic wake_req,
  input  logic mod_sleep_ok_n,
  input  logic mod_rts_n,
  output logic peer_sleep_ok_n,
  output logic peer_cts_n,
  output logic host_sleep_ok,
  output logic host_wake_evt,
  output logic tx_hold,
  output logic wake_timeout
);
  logic [1:0] lines_s;
  logic       waking_next;

  // bit 1: permission line (rests high), bit 0: RTS (rests low)
  lpm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({mod_sleep_ok_n, mod_rts_n}),
    .q   (lines_s)
  );

  lpm_fsm u_fsm (
    .clk             (clk),
    .rst             (rst),
    .sleep_req       (sleep_req),
    .wake_req        (wake_req),
    .mod_ok_n_s      (lines_s[1]),
    .mod_rts_n_s     (lines_s[0]),
    .timeout_flag    (wake_timeout),
    .waking_next     (waking_next),
    .peer_sleep_ok_n (peer_sleep_ok_n),
    .peer_cts_n      (peer_cts_n),
    .host_sleep_ok   (host_sleep_ok),
    .host_wake_evt   (host_wake_evt),
    .tx_hold         (tx_hold)
  );

  lpm_wake_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .in_waking (waking_next),
    .expired   (wake_timeout)
  );
endmodule

// File: tb/sim_lpm_handshake_ctrl.sv
module sim_lpm_handshake_ctrl;
  localparam int LIMIT = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b0, wake_req = 1'b0;
  logic mod_sleep_ok_n = 1'b1, mod_rts_n = 1'b0;
  logic peer_sleep_ok_n, peer_cts_n, host_sleep_ok, host_wake_evt, tx_hold, wake_timeout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lpm_handshake_ctrl #(.TIMEOUT_CYCLES(LIMIT)) u0 (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_req(wake_req),
    .mod_sleep_ok_n(mod_sleep_ok_n), .mod_rts_n(mod_rts_n),
    .peer_sleep_ok_n(peer_sleep_ok_n), .peer_cts_n(peer_cts_n),
    .host_sleep_ok(host_sleep_ok), .host_wake_evt(host_wake_evt),
    .tx_hold(tx_hold), .wake_timeout(wake_timeout)
  );

  // {sleep_req, wake_req, mod_ok_n, mod_rts_n, exp perm_n, exp cts_n, exp sleep_ok, exp evt, exp hold}
  localparam logic [8:0] VEC [20] = '{
    9'b1_0_1_0_1_1_0_0_0, // entry: CTS up
    9'b0_0_1_0_0_1_0_0_0, // grant follows
    9'b1_0_0_1_0_1_0_0_0, // duplicate sleep, module sleeps
    9'b0_0_0_1_0_1_0_0_0,
    9'b0_0_0_1_0_1_1_0_1, // both asleep
    9'b0_1_0_1_0_0_0_0_1, // host wake: CTS down
    9'b0_0_0_1_1_0_0_0_1, // permission up
    9'b0_0_1_0_1_0_0_0_1, // module answers
    9'b0_0_1_0_1_0_0_0_1,
    9'b0_0_1_0_1_0_0_0_0, // awake
    9'b1_0_1_0_1_1_0_0_0, // second entry
    9'b0_0_0_1_0_1_0_0_0,
    9'b0_0_0_1_0_1_0_0_0,
    9'b0_0_0_1_0_1_1_0_1,
    9'b0_0_0_1_0_1_1_0_1,
    9'b0_0_1_0_0_1_1_0_1, // module wakes host
    9'b0_0_1_0_0_1_1_0_1,
    9'b0_0_1_0_0_0_0_1_0, // wake event
    9'b0_0_1_0_1_0_0_0_0,
    9'b0_1_1_0_1_0_0_0_0  // wake while awake ignored
  };

  task automatic cyc(input logic sr, input logic wr, input logic mp, input logic mr);
    @(negedge clk);
    sleep_req = sr; wake_req = wr; mod_sleep_ok_n = mp; mod_rts_n = mr;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 perm", peer_sleep_ok_n, 1'b1);
    chk("R1 cts", peer_cts_n, 1'b0);
    chk("R1 sleep_ok", host_sleep_ok, 1'b0);
    chk("R1 evt", host_wake_evt, 1'b0);
    chk("R1 hold", tx_hold, 1'b0);
    chk("R1 timeout", wake_timeout, 1'b0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < 20; i++) begin
      cyc(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5]);
      chk("R2 R4 perm order", peer_sleep_ok_n, VEC[i][4]);
      chk("R2 R4 cts order", peer_cts_n, VEC[i][3]);
      chk("R3 host sleep", host_sleep_ok, VEC[i][2]);
      chk("R6 wake event", host_wake_evt, VEC[i][1]);
      chk("R7 tx hold", tx_hold, VEC[i][0]);
    end
    chk("R9 wake ignored", peer_cts_n, 1'b0);

    // R10: module lines move while awake
    repeat (3) cyc(0, 0, 0, 1);
    chk("R10 sleep_ok", host_sleep_ok, 1'b0);
    chk("R10 cts", peer_cts_n, 1'b0);
    chk("R10 perm", peer_sleep_ok_n, 1'b1);
    chk("R7 hold up", tx_hold, 1'b1);
    repeat (3) cyc(0, 0, 1, 0);
    chk("R7 hold down", tx_hold, 1'b0);

    // R8 / R5: unanswered host wake
    cyc(1, 0, 1, 0);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 1);
    chk("R3 asleep", host_sleep_ok, 1'b1);
    cyc(0, 1, 0, 1);
    chk("R8 no flag at start", wake_timeout, 1'b0);
    for (int k = 0; k < LIMIT - 2; k++) cyc(0, 0, 0, 1);
    chk("R8 one edge early", wake_timeout, 1'b0);
    cyc(1, 0, 0, 1);
    chk("R8 at limit", wake_timeout, 1'b1);
    chk("R9 sleep ignored while waking", peer_cts_n, 1'b0);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);
    chk("R5 still waking", wake_timeout, 1'b1);
    cyc(0, 0, 1, 0);
    chk("R8 cleared", wake_timeout, 1'b0);
    cyc(1, 0, 1, 0);
    chk("R5 sleep accepted again", peer_cts_n, 1'b1);

    // R1: reset in the middle of a grant
    cyc(0, 0, 1, 0);
    chk("R2 granted", peer_sleep_ok_n, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 mid perm", peer_sleep_ok_n, 1'b1);
    chk("R1 mid cts", peer_cts_n, 1'b0);
    @(negedge clk); rst = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule